// File: doc/BRIEF.md
# Multi-Rail Protection Fault Latch

This block watches three supply rails from the digital side: two switching regulator channels and one linear channel. Every clock it takes synchronous over-voltage and under-voltage comparator flags, the channel enables, the per-channel soft-start completion flags, an under-voltage protection enable strap and a flag that marks a voltage-code transition on switching channel 1. From these it decides whether a fault is real and, if so, drives a sticky shutdown.

An over-voltage fault that qualifies trips the latch on the next clock edge. An under-voltage fault that qualifies first runs a digital delay counter, which stands in for an analog delay capacitor. The latch trips only after the fault has stayed qualified for a set number of consecutive edges. Once tripped, the block stays in shutdown whatever its inputs do. Only a synchronous undervoltage-lockout reset returns it to the armed state.

The state output reports whether the block is armed, timing an under-voltage fault, or latched, and which kind of fault caused the latch.

Top module: `rail_fault_latch`

## Requirements
- R1: After the asynchronous reset `rst_n` is released, `latch_state` is 2'b00 (armed) and `shutdown_cmd` is 0.
- R2: When the block is not latched and at least one bit of `sw_en` is 1, a qualified `ov_flag` bit moves `latch_state` to 2'b10 (latched by over-voltage) at the next edge. With `sw_en` all zero, `ov_flag` has no effect. The linear channel has no over-voltage input.
- R3: While `vid_move` is 1, the flags of channel 1 (`ov_flag[0]`, `uv_sw_flag[0]`) are ignored. Channel 2 (bit 1) is not masked.
- R4: While `uv_prot_en` is 0, no under-voltage flag has any effect: the state never becomes 2'b01 or 2'b11 from an under-voltage flag.
- R5: `uv_sw_flag[i]` qualifies only when both `sw_en[i]` and `ss_done[i]` are 1.
- R6: `uv_lin_flag` qualifies only when at least one bit of `sw_en` is 1 and at least one bit of `ss_done` is 1.
- R7: While any under-voltage flag qualifies and the block is unlatched, `latch_state` is 2'b01. After UV_DELAY_CYC consecutive qualifying edges it becomes 2'b11 (latched by under-voltage). Any edge without a qualifying flag returns the state to 2'b00 and restarts the count.
- R8: Once `latch_state` is 2'b10 or 2'b11, it holds, whatever the flags do, until `uvlo_rst` is applied.
- R9: `uvlo_rst`=1 at an edge sets `latch_state` to 2'b00 and clears the delay count. This takes priority over any trip in the same cycle.
- R10: If an over-voltage trip and the terminal under-voltage edge fall in the same cycle, the recorded cause is over-voltage (2'b10).
- R11: `shutdown_cmd` equals 1 exactly when `latch_state` is 2'b10 or 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uvlo_rst | input | 1 | Synchronous undervoltage-lockout release, active high |
| sw_en | input | N_SW | Switching channel enables, bit 0 = channel 1 |
| ss_done | input | N_SW | Soft-start timeout reached, per switching channel |
| uv_prot_en | input | 1 | Under-voltage protection enable strap |
| vid_move | input | 1 | Channel 1 voltage-code transition in progress |
| ov_flag | input | N_SW | Over-voltage comparator flags, switching channels |
| uv_sw_flag | input | N_SW | Under-voltage comparator flags, switching channels |
| uv_lin_flag | input | 1 | Under-voltage comparator flag, linear channel |
| latch_state | output | 2 | 00 armed, 01 under-voltage timing, 10 latched by over-voltage, 11 latched by under-voltage |
| shutdown_cmd | output | 1 | Shutdown command to all rails |

## Verification
The assertions assume that all inputs are synchronous to `clk` and hold known values at every sampling edge after reset. They also assume that `uvlo_rst` is a plain level input and not a free-running pulse train. The stimulus changes every input only on the falling edge and holds each pattern for whole cycles. It brings `uvlo_rst` in for single deliberate cycles, some of them together with a new trip. The flag patterns cover each masking gate (enable, soft-start, strap, transition mask) on its own, so each gate is opened and closed while the others stay fixed.

// File: rtl/rfl_pkg.sv
package rfl_pkg;

    typedef enum logic [1:0] {
        RFL_ARMED   = 2'b00,
        RFL_UV_WAIT = 2'b01,
        RFL_TRIP_OV = 2'b10,
        RFL_TRIP_UV = 2'b11
    } rfl_state_e;

    typedef struct packed {
        rfl_state_e state;
    } rfl_regs_t;

    function automatic logic rfl_is_latched(rfl_state_e s);
        return s[1];
    endfunction

endpackage

// File: rtl/rfl_ov_qual.sv
module rfl_ov_qual #(
    parameter int N_SW = 2
) (
    input  logic            latched,
    input  logic [N_SW-1:0] sw_en,
    input  logic            vid_move,
    input  logic [N_SW-1:0] ov_flag,
    output logic            ov_trip
);
    logic [N_SW-1:0] ov_qual;
    logic            any_sw_on;

    assign any_sw_on = |sw_en;

    // Channel 1 (bit 0) is masked while its voltage code is moving.
    for (genvar gi = 0; gi < N_SW; gi++) begin : g_ch
        if (gi == 0) begin : g_masked
            assign ov_qual[gi] = ov_flag[gi] & ~vid_move;
        end else begin : g_plain
            assign ov_qual[gi] = ov_flag[gi];
        end
    end

    assign ov_trip = (|ov_qual) & any_sw_on & ~latched;

endmodule

// File: rtl/rfl_uv_qual.sv
module rfl_uv_qual #(
    parameter int N_SW = 2
) (
    input  logic            latched,
    input  logic            uv_prot_en,
    input  logic [N_SW-1:0] sw_en,
    input  logic [N_SW-1:0] ss_done,
    input  logic            vid_move,
    input  logic [N_SW-1:0] uv_sw_flag,
    input  logic            uv_lin_flag,
    output logic            uv_active
);
    logic [N_SW-1:0] sw_qual;
    logic            lin_qual;

    for (genvar gi = 0; gi < N_SW; gi++) begin : g_ch
        logic armed_ch;
        assign armed_ch = sw_en[gi] & ss_done[gi];
        if (gi == 0) begin : g_masked
            assign sw_qual[gi] = uv_sw_flag[gi] & armed_ch & ~vid_move;
        end else begin : g_plain
            assign sw_qual[gi] = uv_sw_flag[gi] & armed_ch;
        end
    end

    assign lin_qual  = uv_lin_flag & (|sw_en) & (|ss_done);
    assign uv_active = uv_prot_en & ~latched & ((|sw_qual) | lin_qual);

endmodule

// File: rtl/rfl_uv_timer.sv
module rfl_uv_timer #(
    parameter int TERM = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic hit
);
    localparam int CNT_W = (TERM > 1) ? $clog2(TERM) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TERM - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign hit = run & (cnt_q == LAST);

    always_comb begin
        cnt_d = cnt_q;
        if (clr || !run || hit) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/rail_fault_latch.sv
module rail_fault_latch #(
    parameter int N_SW         = 2,
    parameter int UV_DELAY_CYC = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            uvlo_rst,
    input  logic [N_SW-1:0] sw_en,
    input  logic [N_SW-1:0] ss_done,
    input  logic            uv_prot_en,
    input  logic            vid_move,
    input  logic [N_SW-1:0] ov_flag,
    input  logic [N_SW-1:0] uv_sw_flag,
    input  logic            uv_lin_flag,
    output logic [1:0]      latch_state,
    output logic            shutdown_cmd
);
    import rfl_pkg::*;

    rfl_regs_t regs_d, regs_q;
    logic      latched;
    logic      ov_trip;
    logic      uv_active;
    logic      uv_hit;

    assign latched = rfl_is_latched(regs_q.state);

    rfl_ov_qual #(.N_SW(N_SW)) ov_qual_i (
        .latched  (latched),
        .sw_en    (sw_en),
        .vid_move (vid_move),
        .ov_flag  (ov_flag),
        .ov_trip  (ov_trip)
    );

    rfl_uv_qual #(.N_SW(N_SW)) uv_qual_i (
        .latched     (latched),
        .uv_prot_en  (uv_prot_en),
        .sw_en       (sw_en),
        .ss_done     (ss_done),
        .vid_move    (vid_move),
        .uv_sw_flag  (uv_sw_flag),
        .uv_lin_flag (uv_lin_flag),
        .uv_active   (uv_active)
    );

    rfl_uv_timer #(.TERM(UV_DELAY_CYC)) uv_timer_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (uvlo_rst | ov_trip),
        .run   (uv_active),
        .hit   (uv_hit)
    );

    // Lockout release wins over everything; a latched state holds;
    // over-voltage outranks the under-voltage terminal count.
    always_comb begin
        regs_d = regs_q;
        if (uvlo_rst) begin
            regs_d.state = RFL_ARMED;
        end else if (latched) begin
            regs_d.state = regs_q.state;
        end else if (ov_trip) begin
            regs_d.state = RFL_TRIP_OV;
        end else if (uv_hit) begin
            regs_d.state = RFL_TRIP_UV;
        end else if (uv_active) begin
            regs_d.state = RFL_UV_WAIT;
        end else begin
            regs_d.state = RFL_ARMED;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.state <= RFL_ARMED;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign latch_state  = regs_q.state;
    assign shutdown_cmd = latched;

endmodule

// File: rtl/rfl_checker.sv
module rfl_checker #(
    parameter int N_SW         = 2,
    parameter int UV_DELAY_CYC = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            uvlo_rst,
    input logic [N_SW-1:0] sw_en,
    input logic [N_SW-1:0] ss_done,
    input logic            uv_prot_en,
    input logic            vid_move,
    input logic [N_SW-1:0] ov_flag,
    input logic [N_SW-1:0] uv_sw_flag,
    input logic            uv_lin_flag,
    input logic [1:0]      latch_state,
    input logic            shutdown_cmd
);
    // R8: a latched shutdown persists until lockout release
    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (shutdown_cmd && !uvlo_rst) |=> (shutdown_cmd && $stable(latch_state)));

    // R9: lockout release always returns to armed
    p_uvlo_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        uvlo_rst |=> (latch_state == 2'b00));

    // R2: unmasked channel over-voltage with a channel on trips at once
    p_ov_trip_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!shutdown_cmd && !uvlo_rst && (|sw_en) && ov_flag[N_SW-1])
        |=> (latch_state == 2'b10));

    // R3: channel 1 over-voltage alone during a code transition does not trip
    p_vid_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_state == 2'b00 && vid_move && ov_flag[0] && !(|ov_flag[N_SW-1:1])
         && !uv_prot_en) |=> (latch_state == 2'b00));

    // R4: with protection strapped off, no under-voltage progress from armed
    p_uv_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_state == 2'b00 && !uv_prot_en) |=> (latch_state[0] == 1'b0));

    // R7: the under-voltage latch is never entered straight from armed
    if (UV_DELAY_CYC > 1) begin : g_delay
        p_no_direct_uv_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (latch_state == 2'b00) |=> (latch_state != 2'b11));
    end

    // R11: shutdown tracks the latched states
    p_shutdown_map_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shutdown_cmd) |-> latch_state[1]);

endmodule

bind rail_fault_latch rfl_checker #(.N_SW(N_SW), .UV_DELAY_CYC(UV_DELAY_CYC)) chk_i (.*);

// File: tb/rail_fault_latch_tb_top.sv
`timescale 1ns/1ps
module rail_fault_latch_tb_top;
    localparam int N_SW = 2;
    localparam int TERM = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            uvlo_rst = 1'b0;
    logic [N_SW-1:0] sw_en = '0;
    logic [N_SW-1:0] ss_done = '0;
    logic            uv_prot_en = 1'b0;
    logic            vid_move = 1'b0;
    logic [N_SW-1:0] ov_flag = '0;
    logic [N_SW-1:0] uv_sw_flag = '0;
    logic            uv_lin_flag = 1'b0;
    logic [1:0]      latch_state;
    logic            shutdown_cmd;

    int    n_checks = 0;
    int    n_errors = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    int m_state = 0;
    int m_cnt   = 0;

    always #5 clk = ~clk;

    rail_fault_latch #(.N_SW(N_SW), .UV_DELAY_CYC(TERM)) dut_i (
        .clk(clk), .rst_n(rst_n), .uvlo_rst(uvlo_rst), .sw_en(sw_en),
        .ss_done(ss_done), .uv_prot_en(uv_prot_en), .vid_move(vid_move),
        .ov_flag(ov_flag), .uv_sw_flag(uv_sw_flag), .uv_lin_flag(uv_lin_flag),
        .latch_state(latch_state), .shutdown_cmd(shutdown_cmd)
    );

    // Behavioural reference: plain integers, written from the requirements.
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_state = 0;
            m_cnt   = 0;
        end else begin
            bit any_on, ovq, uvq;
            any_on = (sw_en != 0);
            ovq = any_on && (ov_flag[1] || (ov_flag[0] && !vid_move));
            uvq = uv_prot_en && (
                  (uv_sw_flag[1] && sw_en[1] && ss_done[1]) ||
                  (uv_sw_flag[0] && sw_en[0] && ss_done[0] && !vid_move) ||
                  (uv_lin_flag && any_on && ss_done != 0));
            if (uvlo_rst) begin
                m_state = 0; m_cnt = 0;
            end else if (m_state >= 2) begin
                m_cnt = 0;
            end else if (ovq) begin
                m_state = 2; m_cnt = 0;
            end else if (uvq) begin
                m_cnt = m_cnt + 1;
                if (m_cnt >= TERM) begin
                    m_state = 3; m_cnt = 0;
                end else begin
                    m_state = 1;
                end
            end else begin
                m_state = 0; m_cnt = 0;
            end
        end
    end

    task automatic compare();
        n_checks++;
        if (latch_state !== 2'(m_state)) begin
            n_errors++;
            $display("FAIL %s: latch_state actual=%0d expected=%0d at %0t",
                     cur_req, latch_state, m_state, $time);
        end
        n_checks++;
        if (shutdown_cmd !== (m_state >= 2)) begin
            n_errors++;
            $display("FAIL %s/R11: shutdown_cmd actual=%0b expected=%0b at %0t",
                     cur_req, shutdown_cmd, (m_state >= 2), $time);
        end
    endtask

    task automatic expect_state(input logic [1:0] exp, input string req);
        n_checks++;
        if (latch_state !== exp) begin
            n_errors++;
            $display("FAIL %s: latch_state actual=%0d expected=%0d at %0t",
                     req, latch_state, exp, $time);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare();
        end
    endtask

    task automatic quiet();
        ov_flag = '0; uv_sw_flag = '0; uv_lin_flag = 1'b0; vid_move = 1'b0;
    endtask

    task automatic release_lock();
        quiet();
        uvlo_rst = 1'b1;
        cyc(1);
        uvlo_rst = 1'b0;
        expect_state(2'b00, "R9");
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        cyc(2);
        rst_n = 1'b1;
        cur_req = "R1";
        cyc(2);
        expect_state(2'b00, "R1");

        // R2: no switching channel on, over-voltage ignored
        cur_req = "R2";
        ov_flag = 2'b10;
        cyc(3);
        expect_state(2'b00, "R2");
        sw_en = 2'b01;
        cyc(1);
        expect_state(2'b10, "R2");
        // R8: fault removed, latch holds
        cur_req = "R8";
        quiet();
        uv_prot_en = 1'b1; ss_done = 2'b11; uv_sw_flag = 2'b11;
        cyc(TERM + 3);
        expect_state(2'b10, "R8");
        cur_req = "R9";
        release_lock();
        uv_prot_en = 1'b0;

        // R3: channel 1 masked during transition, channel 2 not
        cur_req = "R3";
        sw_en = 2'b11; vid_move = 1'b1; ov_flag = 2'b01;
        cyc(3);
        expect_state(2'b00, "R3");
        uv_prot_en = 1'b1; ov_flag = 2'b00; uv_sw_flag = 2'b01;
        cyc(TERM + 2);
        expect_state(2'b00, "R3");
        uv_sw_flag = 2'b00; ov_flag = 2'b10;
        cyc(1);
        expect_state(2'b10, "R3");
        release_lock();

        // R4: strap off, all under-voltage flags ignored
        cur_req = "R4";
        uv_prot_en = 1'b0; uv_sw_flag = 2'b11; uv_lin_flag = 1'b1;
        cyc(TERM + 4);
        expect_state(2'b00, "R4");
        quiet();

        // R5: per-channel enable and soft-start gating
        cur_req = "R5";
        uv_prot_en = 1'b1; sw_en = 2'b01; ss_done = 2'b00; uv_sw_flag = 2'b01;
        cyc(TERM + 2);
        expect_state(2'b00, "R5");
        uv_sw_flag = 2'b10; ss_done = 2'b11;
        cyc(TERM + 2);
        expect_state(2'b00, "R5");
        uv_sw_flag = 2'b01;
        cyc(1);
        expect_state(2'b01, "R5");

        // R7: interrupted count restarts, then full delay trips
        cur_req = "R7";
        cyc(4);
        uv_sw_flag = 2'b00;
        cyc(1);
        expect_state(2'b00, "R7");
        uv_sw_flag = 2'b01;
        cyc(TERM - 1);
        expect_state(2'b01, "R7");
        cyc(1);
        expect_state(2'b11, "R7");
        release_lock();

        // R6: linear channel gating
        cur_req = "R6";
        sw_en = 2'b00; ss_done = 2'b11; uv_lin_flag = 1'b1;
        cyc(TERM + 2);
        expect_state(2'b00, "R6");
        sw_en = 2'b10; ss_done = 2'b00;
        cyc(TERM + 2);
        expect_state(2'b00, "R6");
        ss_done = 2'b01;
        cyc(TERM);
        expect_state(2'b11, "R6");
        release_lock();

        // R9: release has priority over a trip in the same cycle
        cur_req = "R9";
        sw_en = 2'b11; ss_done = 2'b11;
        uv_sw_flag = 2'b10;
        cyc(3);
        uvlo_rst = 1'b1; ov_flag = 2'b10;
        cyc(1);
        expect_state(2'b00, "R9");
        uvlo_rst = 1'b0; ov_flag = 2'b00;
        cyc(TERM - 1);
        expect_state(2'b01, "R9");
        cyc(1);
        expect_state(2'b11, "R9");
        release_lock();

        // R10: over-voltage wins on the terminal under-voltage edge
        cur_req = "R10";
        uv_lin_flag = 1'b1;
        cyc(TERM - 1);
        ov_flag = 2'b01;
        cyc(1);
        expect_state(2'b10, "R10");
        release_lock();
        cyc(2);

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule